// File: doc/BRIEF.md
# Display Interrupt Status and Acknowledge Hub

This block collects the per-head display timing interrupts and the per-connector hotplug interrupts for a display engine. Each display head can raise a vertical-blank event and a programmable-line event. Each hotplug connector can raise a connection-change event. An event that arrives while its source is enabled is latched into a sticky status bit. Latching a status bit queues exactly one interrupt vector towards the ring writer. The vector carries an 8-bit source id and a source data field that name the event.

Software programs the hub through a small register port. It sets per-head masks and per-connector hotplug controls, reads the status words, and clears each status bit through its own acknowledge register. The number of active heads is a parameter (2, 4 or 6). Events and writes aimed at heads that are not built are ignored. A single disable-all command turns off every source but keeps each connector's polarity setting. Vectors leave through a valid/ready pair, one per accepted transfer. The vector on offer stays fixed until it is taken.

Register map (6-bit address, 8-bit data). The group is address bits [5:3] and the index is address bits [2:0].
- Group 0, status word k, read only: bit0 vblank of head k+1, bit1 vline of head k+1, bit2 hotplug of connector k.
- Group 1, head mask k: bit0 vblank consumer, bit1 vline enable, bit2 page flip pending.
- Group 2, vblank status and ack k: reads bit0 status; writing bit0=1 clears it.
- Group 3, vline status and ack k: the same, for vline.
- Group 4, hotplug control k: bit0 enable, bit1 ack (write 1 clears, reads 0), bit2 polarity.
- Address 0x3F: disable-all command.

Top module: `disp_irq_hub`

## Requirements
- R1: After reset all status bits, head masks, hotplug enables and polarity bits read 0, and vec_valid is 0.
- R2: A vblank event on a built head sets that head's vblank status only when mask bit0 (consumer) or mask bit2 (page flip pending) is 1; otherwise it leaves no trace.
- R3: A vline event sets that head's vline status only when mask bit1 is 1.
- R4: Status word k (address 0x00+k) shows head k+1 vblank in bit0, head k+1 vline in bit1 and connector k hotplug in bit2.
- R5: Writing bit0=1 to address 0x10+k clears only head k+1 vblank status. Writing bit0=1 to 0x18+k clears only its vline status.
- R6: Hotplug control 0x20+k gates connector k events with bit0 and stores polarity in bit2. Writing bit1=1 clears the connector's hotplug status, and bit1 always reads 0.
- R7: A write to address 0x3F clears every head mask bit and every hotplug enable. Polarity bits and status bits are left unchanged.
- R8: A vblank vector has source id equal to the head number (1 to 6) and data 0. A vline vector has the same id and data 1. A hotplug vector has id 42 and data equal to the connector index (0 to 5).
- R9: Each status bit that goes from clear to set yields exactly one vector. An event that arrives while its status bit is already set yields none.
- R10: Queued vectors leave one per cycle with vec_valid and vec_ready both high. The lowest index goes first, in the order head1 vblank, head1 vline, head2 vblank, and so on, then hotplug 0 to 5. While vec_ready is low, the offered vector does not change.
- R11: When an acknowledge and a new enabled event hit the same status bit in the same cycle, the bit stays set.
- R12: For heads numbered above NUM_HEADS, events are ignored, mask writes are dropped, and their status and mask registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (group in [5:3], index in [2:0]) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| vblank_evt | input | 6 | Per-head vblank event pulses |
| vline_evt | input | 6 | Per-head vline event pulses |
| hpd_evt | input | NUM_HPD (6) | Per-connector hotplug event pulses |
| vec_valid | output | 1 | Interrupt vector offered |
| vec_ready | input | 1 | Ring writer accepts the vector |
| vec_src_id | output | 8 | Vector source id |
| vec_src_data | output | SRC_DATA_W (28) | Vector source data |

## Verification
Two cases are hard to reach. The first is holding a vector while a higher-priority source becomes pending behind it. The stimulus parks vec_ready low on a hotplug vector, then fires a head-1 vblank and checks that the hotplug vector is still on offer and delivered first. The second is an acknowledge that lands in the very cycle of a new event. The bench drives the ack write and the event pulse on the same edge, while the status bit is already set, and confirms the bit survives and no second vector appears.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int MAX_HEADS  = 6;
  localparam int MAX_HPD    = 6;
  localparam int REG_AW     = 6;
  localparam int REG_DW     = 8;
  localparam int SRC_ID_W   = 8;

  localparam logic [SRC_ID_W-1:0] HPD_SRC_ID = 8'd42;

  typedef enum logic [2:0] {
    GRP_STATUS = 3'd0,
    GRP_MASK   = 3'd1,
    GRP_VBACK  = 3'd2,
    GRP_VLACK  = 3'd3,
    GRP_HPD    = 3'd4,
    GRP_CMD    = 3'd7
  } reg_grp_e;

  localparam int MSK_VB_REQ = 0;
  localparam int MSK_VL_EN  = 1;
  localparam int MSK_FLIP   = 2;
  localparam int HPC_EN     = 0;
  localparam int HPC_ACK    = 1;
  localparam int HPC_POL    = 2;
  localparam int STW_VB     = 0;
  localparam int STW_VL     = 1;
  localparam int STW_HPD    = 2;
endpackage

// File: rtl/disp_irq_cell.sv
module disp_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic en,
  input  logic ack,
  input  logic grant,
  output logic stat,
  output logic pend
);
  logic stat_d, pend_d, hit, set_new;

  always_comb begin
    hit     = ev & en;
    set_new = hit & ~stat;
    stat_d  = hit | (stat & ~ack);
    pend_d  = set_new | (pend & ~grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= 1'b0;
      pend <= 1'b0;
    end else begin
      stat <= stat_d;
      pend <= pend_d;
    end
  end

  // R2
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && en) |=> stat);
  // R2
  stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat && !(ev && en)) |=> !stat);
  // R5
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(ev && en)) |=> !stat);
  // R9
  vec_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && en && !stat) |=> pend);
endmodule

// File: rtl/disp_irq_arb.sv
module disp_irq_arb #(
  parameter int N  = 14,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  input  logic          ready,
  output logic          valid,
  output logic [IW-1:0] sel,
  output logic [N-1:0]  grant
);
  logic [IW-1:0] first, hold_idx_q, hold_idx_d;
  logic          found, hold_vld_q, hold_vld_d, hold_ce;

  always_comb begin
    first = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !found) begin
        first = IW'(i);
        found = 1'b1;
      end
    end
    valid = |pend;
    sel   = hold_vld_q ? hold_idx_q : first;
    grant = '0;
    if (valid && ready) grant[sel] = 1'b1;
    hold_vld_d = valid && !ready;
    hold_idx_d = sel;
    hold_ce    = valid || hold_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_idx_q <= '0;
    end else if (hold_ce) begin
      hold_vld_q <= hold_vld_d;
      hold_idx_q <= hold_idx_d;
    end
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(sel)));
endmodule

// File: rtl/disp_irq_hub.sv
module disp_irq_hub
  import disp_irq_pkg::*;
#(
  parameter int NUM_HEADS  = 4,
  parameter int NUM_HPD    = 6,
  parameter int SRC_DATA_W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [REG_DW-1:0]     reg_wdata,
  output logic [REG_DW-1:0]     reg_rdata,
  input  logic [MAX_HEADS-1:0]  vblank_evt,
  input  logic [MAX_HEADS-1:0]  vline_evt,
  input  logic [NUM_HPD-1:0]    hpd_evt,
  output logic                  vec_valid,
  input  logic                  vec_ready,
  output logic [SRC_ID_W-1:0]   vec_src_id,
  output logic [SRC_DATA_W-1:0] vec_src_data
);
  localparam int HB   = 2 * NUM_HEADS;
  localparam int NSRC = HB + NUM_HPD;
  localparam int IW   = $clog2(NSRC);

  reg_grp_e   grp;
  logic [2:0] ridx;
  logic       cfg_we, cmd_off;

  logic [MAX_HEADS-1:0] vbreq_q, vbreq_d, flip_q, flip_d, vlen_q, vlen_d;
  logic [MAX_HPD-1:0]   hpen_q, hpen_d, hpol_q, hpol_d;
  logic [MAX_HEADS-1:0] vb_stat, vl_stat;
  logic [MAX_HPD-1:0]   hp_stat;
  logic [NSRC-1:0]      src_pend, src_grant;
  logic [IW-1:0]        sel;
  logic                 unused_in;

  assign grp       = reg_grp_e'(reg_addr[5:3]);
  assign ridx      = reg_addr[2:0];
  assign cfg_we    = reg_we;
  assign cmd_off   = reg_we && (grp == GRP_CMD) && (ridx == 3'd7);
  assign unused_in = ^{vblank_evt, vline_evt, reg_wdata};

  // configuration next state
  always_comb begin
    vbreq_d = vbreq_q;
    flip_d  = flip_q;
    vlen_d  = vlen_q;
    hpen_d  = hpen_q;
    hpol_d  = hpol_q;
    if (grp == GRP_MASK && int'(ridx) < NUM_HEADS) begin
      vbreq_d[ridx] = reg_wdata[MSK_VB_REQ];
      vlen_d[ridx]  = reg_wdata[MSK_VL_EN];
      flip_d[ridx]  = reg_wdata[MSK_FLIP];
    end
    if (grp == GRP_HPD && int'(ridx) < NUM_HPD) begin
      hpen_d[ridx] = reg_wdata[HPC_EN];
      hpol_d[ridx] = reg_wdata[HPC_POL];
    end
    if (cmd_off) begin
      vbreq_d = '0;
      flip_d  = '0;
      vlen_d  = '0;
      hpen_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbreq_q <= '0;
      flip_q  <= '0;
      vlen_q  <= '0;
      hpen_q  <= '0;
      hpol_q  <= '0;
    end else if (cfg_we) begin
      vbreq_q <= vbreq_d;
      flip_q  <= flip_d;
      vlen_q  <= vlen_d;
      hpen_q  <= hpen_d;
      hpol_q  <= hpol_d;
    end
  end

  // per-head status cells
  for (genvar h = 0; h < MAX_HEADS; h++) begin : g_head
    if (h < NUM_HEADS) begin : g_on
      logic vb_ack, vl_ack;
      assign vb_ack = reg_we && (grp == GRP_VBACK) && (ridx == 3'(h)) && reg_wdata[0];
      assign vl_ack = reg_we && (grp == GRP_VLACK) && (ridx == 3'(h)) && reg_wdata[0];
      disp_irq_cell u_vb (
        .clk(clk), .rst_n(rst_n), .ev(vblank_evt[h]),
        .en(vbreq_q[h] | flip_q[h]), .ack(vb_ack), .grant(src_grant[2*h]),
        .stat(vb_stat[h]), .pend(src_pend[2*h]));
      disp_irq_cell u_vl (
        .clk(clk), .rst_n(rst_n), .ev(vline_evt[h]),
        .en(vlen_q[h]), .ack(vl_ack), .grant(src_grant[2*h+1]),
        .stat(vl_stat[h]), .pend(src_pend[2*h+1]));
    end else begin : g_off
      assign vb_stat[h] = 1'b0;
      assign vl_stat[h] = 1'b0;
    end
  end

  // per-connector hotplug cells
  for (genvar c = 0; c < MAX_HPD; c++) begin : g_hpd
    if (c < NUM_HPD) begin : g_on
      logic hp_ack;
      assign hp_ack = reg_we && (grp == GRP_HPD) && (ridx == 3'(c)) && reg_wdata[HPC_ACK];
      disp_irq_cell u_hp (
        .clk(clk), .rst_n(rst_n), .ev(hpd_evt[c]),
        .en(hpen_q[c]), .ack(hp_ack), .grant(src_grant[HB+c]),
        .stat(hp_stat[c]), .pend(src_pend[HB+c]));
    end else begin : g_off
      assign hp_stat[c] = 1'b0;
    end
  end

  disp_irq_arb #(.N(NSRC), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(src_pend), .ready(vec_ready),
    .valid(vec_valid), .sel(sel), .grant(src_grant));

  // vector encoding
  always_comb begin
    if (int'(sel) < HB) begin
      vec_src_id   = SRC_ID_W'(int'(sel) / 2 + 1);
      vec_src_data = SRC_DATA_W'(int'(sel) % 2);
    end else begin
      vec_src_id   = HPD_SRC_ID;
      vec_src_data = SRC_DATA_W'(int'(sel) - HB);
    end
  end

  // register read
  always_comb begin
    reg_rdata = '0;
    if (int'(ridx) < MAX_HEADS) begin
      case (grp)
        GRP_STATUS: begin
          reg_rdata[STW_VB]  = vb_stat[ridx];
          reg_rdata[STW_VL]  = vl_stat[ridx];
          reg_rdata[STW_HPD] = hp_stat[ridx];
        end
        GRP_MASK: begin
          reg_rdata[MSK_VB_REQ] = vbreq_q[ridx];
          reg_rdata[MSK_VL_EN]  = vlen_q[ridx];
          reg_rdata[MSK_FLIP]   = flip_q[ridx];
        end
        GRP_VBACK: reg_rdata[0] = vb_stat[ridx];
        GRP_VLACK: reg_rdata[0] = vl_stat[ridx];
        GRP_HPD: begin
          reg_rdata[HPC_EN]  = hpen_q[ridx];
          reg_rdata[HPC_POL] = hpol_q[ridx];
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  // R7
  pol_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> ($stable(hpol_q) && (hpen_q == '0) && (vbreq_q == '0)));
endmodule

// File: tb/disp_irq_hub_test.sv
`timescale 1ns/1ps
module disp_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [5:0]  vblank_evt = '0, vline_evt = '0, hpd_evt = '0;
  logic        vec_valid, vec_ready = 1'b0;
  logic [7:0]  vec_src_id;
  logic [27:0] vec_src_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disp_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vblank_evt(vblank_evt),
    .vline_evt(vline_evt), .hpd_evt(hpd_evt), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_src_id(vec_src_id), .vec_src_data(vec_src_data));

  // {kind(0 vblank,1 vline,2 hotplug), index, expected id, expected data}
  localparam logic [15:0] VEC [14] = '{
    {2'd0, 3'd0, 8'd1, 3'd0}, {2'd1, 3'd0, 8'd1, 3'd1},
    {2'd0, 3'd1, 8'd2, 3'd0}, {2'd1, 3'd1, 8'd2, 3'd1},
    {2'd0, 3'd2, 8'd3, 3'd0}, {2'd1, 3'd2, 8'd3, 3'd1},
    {2'd0, 3'd3, 8'd4, 3'd0}, {2'd1, 3'd3, 8'd4, 3'd1},
    {2'd2, 3'd0, 8'd42, 3'd0}, {2'd2, 3'd1, 8'd42, 3'd1},
    {2'd2, 3'd2, 8'd42, 3'd2}, {2'd2, 3'd3, 8'd42, 3'd3},
    {2'd2, 3'd4, 8'd42, 3'd4}, {2'd2, 3'd5, 8'd42, 3'd5}};

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output int v);
    reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic pulse(logic [5:0] vb, logic [5:0] vl, logic [5:0] hp);
    vblank_evt = vb; vline_evt = vl; hpd_evt = hp;
    tick();
    vblank_evt = '0; vline_evt = '0; hpd_evt = '0;
  endtask

  task automatic take();
    vec_ready = 1'b1;
    tick();
    vec_ready = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 vec_valid", int'(vec_valid), 0);
    for (int k = 0; k < 6; k++) begin
      rd(6'(k), v);        chk("R1 status", v, 0);
      rd(6'(8 + k), v);    chk("R1 mask", v, 0);
      rd(6'(32 + k), v);   chk("R1 hpd ctrl", v, 0);
    end

    // table walk: R8 encoding, R4 layout, R5/R6 ack
    for (int h = 0; h < 4; h++) wr(6'(8 + h), 8'h03);
    for (int c = 0; c < 6; c++) wr(6'(32 + c), 8'h01);
    for (int i = 0; i < 14; i++) begin
      logic [1:0] kind; logic [2:0] idx; logic [7:0] eid; logic [2:0] edat;
      {kind, idx, eid, edat} = VEC[i];
      pulse(kind == 2'd0 ? 6'(1 << idx) : 6'd0,
            kind == 2'd1 ? 6'(1 << idx) : 6'd0,
            kind == 2'd2 ? 6'(1 << idx) : 6'd0);
      chk("R8 valid", int'(vec_valid), 1);
      chk("R8 id", int'(vec_src_id), int'(eid));
      chk("R8 data", int'(vec_src_data), int'(edat));
      rd(6'(idx), v); chk("R4 status word", v, 1 << kind);
      take();
      chk("R9 single vector", int'(vec_valid), 0);
      if (kind == 2'd0) wr(6'(16 + idx), 8'h01);
      else if (kind == 2'd1) wr(6'(24 + idx), 8'h01);
      else wr(6'(32 + idx), 8'h03);
      rd(6'(idx), v); chk("R5 R6 ack clears", v, 0);
    end

    // R2: masked vblank ignored, flip bit enables it
    wr(6'h08, 8'h00);
    pulse(6'b000001, 0, 0);
    chk("R2 masked valid", int'(vec_valid), 0);
    rd(6'h00, v); chk("R2 masked status", v, 0);
    wr(6'h08, 8'h04);
    pulse(6'b000001, 0, 0);
    chk("R2 flip valid", int'(vec_valid), 1);
    chk("R2 flip id", int'(vec_src_id), 1);
    take(); wr(6'h10, 8'h01);

    // R3: vline enable only
    wr(6'h09, 8'h02);
    pulse(6'b000010, 0, 0);
    chk("R3 vblank off", int'(vec_valid), 0);
    pulse(0, 6'b000010, 0);
    chk("R3 vline data", int'(vec_src_data), 1);
    take(); wr(6'h19, 8'h01);

    // R5: acks are independent
    wr(6'h0A, 8'h03);
    pulse(6'b000100, 6'b000100, 0);
    take(); take();
    wr(6'h12, 8'h01);
    rd(6'h02, v); chk("R5 vline kept", v, 2);
    wr(6'h1A, 8'h01);
    rd(6'h02, v); chk("R5 vline cleared", v, 0);

    // R6: enable gate, polarity, ack bit reads 0
    wr(6'h23, 8'h04);
    pulse(0, 0, 6'b001000);
    chk("R6 disabled", int'(vec_valid), 0);
    rd(6'h23, v); chk("R6 polarity", v, 4);
    wr(6'h23, 8'h05);
    pulse(0, 0, 6'b001000);
    rd(6'h03, v); chk("R6 status set", v, 4);
    take();
    wr(6'h23, 8'h07);
    rd(6'h23, v); chk("R6 ack reads 0", v, 5);
    rd(6'h03, v); chk("R6 status cleared", v, 0);

    // R9: repeat while set gives no vector
    wr(6'h08, 8'h01);
    pulse(6'b000001, 0, 0);
    take();
    pulse(6'b000001, 0, 0);
    chk("R9 no repeat", int'(vec_valid), 0);

    // R11: ack and event in the same cycle
    reg_we = 1'b1; reg_addr = 6'h10; reg_wdata = 8'h01; vblank_evt = 6'b000001;
    tick();
    reg_we = 1'b0; vblank_evt = '0;
    rd(6'h00, v); chk("R11 stays set", v, 1);
    wr(6'h10, 8'h01);
    rd(6'h00, v); chk("R11 later ack", v, 0);

    // R10: hold while stalled, then priority order
    pulse(0, 0, 6'b000001);
    chk("R10 first id", int'(vec_src_id), 42);
    pulse(6'b000001, 0, 0);
    chk("R10 held id", int'(vec_src_id), 42);
    chk("R10 held data", int'(vec_src_data), 0);
    take();
    chk("R10 next id", int'(vec_src_id), 1);
    take();
    chk("R10 drained", int'(vec_valid), 0);
    wr(6'h10, 8'h01); wr(6'h20, 8'h03);
    pulse(6'b000001, 6'b000010, 0);
    chk("R10 low first", int'(vec_src_id), 1);
    take();
    chk("R10 then head2", int'(vec_src_id), 2);
    chk("R10 then vline", int'(vec_src_data), 1);
    take();
    wr(6'h10, 8'h01); wr(6'h19, 8'h01);

    // R7: disable-all keeps polarity
    wr(6'h21, 8'h05);
    wr(6'h3F, 8'h00);
    rd(6'h21, v); chk("R7 polarity kept", v, 4);
    rd(6'h08, v); chk("R7 mask cleared", v, 0);
    pulse(0, 0, 6'b000010);
    chk("R7 hotplug off", int'(vec_valid), 0);

    // R12: head 5 absent with four heads
    wr(6'h0C, 8'h07);
    rd(6'h0C, v); chk("R12 mask dropped", v, 0);
    pulse(6'b010000, 6'b010000, 0);
    chk("R12 no vector", int'(vec_valid), 0);
    rd(6'h04, v); chk("R12 status", v, 0);

    finish_run();
  end
endmodule